// File: doc/BRIEF.md
# Multi-rate TDM serial stream transmitter

This block serialises per-channel data into a single time-division multiplexed output stream built from 125 µs frames. It runs from a 16.384 MHz clock, so every frame is 2048 clocks long. It has four formats. The first three send 8-bit channels: 32 channels at 2.048 Mb/s, 64 channels at 4.096 Mb/s and 128 channels at 8.192 Mb/s. The fourth is a sub-rate format that sends 128 two-bit channels on a 2.048 Mb/s stream.

A one-clock frame strobe aligns the bit, slot and channel counters. The block does not send anything until the first strobe arrives. During each slot it shows the index of the following slot on a request port, so that a parallel source such as a switching memory can present that channel's data and per-channel drive enable. The block loads these values at the slot boundary and shifts them out MSB first. A clear enable sets the output to high impedance for that slot. The format input is sampled only on frame strobes. Without a strobe the counters wrap on their own at the frame length.

Top module: `tdm_tx`

## Requirements
- R1: After reset and until the first frame strobe is sampled, ser_oe_o is low, ch_req_o is 0 and ch_req_vld_o is low.
- R2: The mode_i encoding is as follows. 0 gives 32 channels of 8 bits at 8 clocks per bit. 1 gives 64 channels of 8 bits at 4 clocks per bit. 2 gives 128 channels of 8 bits at 2 clocks per bit. 3 gives 128 channels of 2 bits at 8 clocks per bit. Every frame is 2048 clocks.
- R3: In the 8-bit modes, data_i[7] of a channel is sent first and data_i[0] last.
- R4: In sub-rate mode (3), only data_i[1:0] is sent: data_i[1] first, then data_i[0].
- R5: Bit 0 of channel 0 appears on ser_o in the cycle after the clock edge at which frame_i is sampled high. data_i and en_i are captured at the edge where each slot begins.
- R6: ch_req_o holds the index of the slot that follows the current one, wrapping to 0 after the last channel. ch_req_vld_o is high for exactly the last bit-time of every slot.
- R7: ser_oe_o equals the en_i captured for the slot in progress. When it is low, the stream is high impedance for that slot.
- R8: A change of mode_i between strobes does not alter the current frame. The new mode is taken only at the edge where frame_i is sampled high.
- R9: If no strobe arrives, the counters wrap after the last channel. The next frame then continues in the mode already active, whatever mode_i shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-clock frame-start strobe |
| mode_i | input | 2 | Rate / format select, applied at frame start |
| data_i | input | 8 | Data for the channel shown on ch_req_o |
| en_i | input | 1 | Drive enable for the channel shown on ch_req_o |
| ch_req_o | output | 7 | Index of the next slot |
| ch_req_vld_o | output | 1 | High during the final bit-time of a slot |
| ser_o | output | 1 | Serial data, MSB first |
| ser_oe_o | output | 1 | Output driver enable for the three-state pin |

## Verification
The stream is run through a sequence of frames that covers all four modes, including consecutive frames in different modes. Each frame uses a data seed that gives every channel a different byte and a rotating pattern of disabled slots. Each bit is checked against the expected byte bit, which separates MSB-first from LSB-first order, a wrong divider, and a channel count that is off by one slot. In the sub-rate frames, a design that sends the high bits of the byte is caught. In every frame mode_i is changed halfway through, so a design that applies the mode before the strobe corrupts the second half. A final frame without a strobe, sent while mode_i differs from the active mode, shows whether the counters wrap on their own.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    MODE_2M  = 2'd0,
    MODE_4M  = 2'd1,
    MODE_8M  = 2'd2,
    MODE_SUB = 2'd3
  } tx_mode_e;
endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing
  import tdm_tx_pkg::*;
#(
  parameter int unsigned MAX_CH   = 128,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SUB_W    = 2,
  parameter int unsigned BASE_DIV = 8,
  localparam int unsigned CH_W    = $clog2(MAX_CH),
  localparam int unsigned BIT_W   = $clog2(BYTE_W),
  localparam int unsigned DIV_W   = $clog2(BASE_DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  tx_mode_e        mode_i,
  output logic            load_o,
  output logic            shift_o,
  output logic            sub_next_o,
  output logic [CH_W-1:0] ch_next_o,
  output logic            req_vld_o
);
  logic             synced_q;
  tx_mode_e         mode_q;
  logic [DIV_W-1:0] div_q, div_last;
  logic [BIT_W-1:0] bit_q, bit_last;
  logic [CH_W-1:0]  ch_q, ch_last;
  logic             tick, slot_end, ch_wrap;

  always_comb begin
    unique case (mode_q)
      MODE_2M: begin
        div_last = DIV_W'(BASE_DIV - 1);
        bit_last = BIT_W'(BYTE_W - 1);
        ch_last  = CH_W'(MAX_CH / 4 - 1);
      end
      MODE_4M: begin
        div_last = DIV_W'(BASE_DIV / 2 - 1);
        bit_last = BIT_W'(BYTE_W - 1);
        ch_last  = CH_W'(MAX_CH / 2 - 1);
      end
      MODE_8M: begin
        div_last = DIV_W'(BASE_DIV / 4 - 1);
        bit_last = BIT_W'(BYTE_W - 1);
        ch_last  = CH_W'(MAX_CH - 1);
      end
      default: begin
        div_last = DIV_W'(BASE_DIV - 1);
        bit_last = BIT_W'(SUB_W - 1);
        ch_last  = CH_W'(MAX_CH - 1);
      end
    endcase
  end

  assign tick       = synced_q && (div_q == div_last);
  assign slot_end   = tick && (bit_q == bit_last);
  assign ch_wrap    = (ch_q == ch_last);
  assign load_o     = frame_i || slot_end;
  assign shift_o    = tick && !slot_end && !frame_i;
  assign sub_next_o = frame_i ? (mode_i == MODE_SUB) : (mode_q == MODE_SUB);
  assign ch_next_o  = (!synced_q || ch_wrap) ? '0 : CH_W'(ch_q + 1'b1);
  assign req_vld_o  = synced_q && (bit_q == bit_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q <= 1'b0;
      mode_q   <= MODE_2M;
      div_q    <= '0;
      bit_q    <= '0;
      ch_q     <= '0;
    end else begin
      if (frame_i) begin
        synced_q <= 1'b1;
        mode_q   <= mode_i;
      end
      if (load_o) begin
        div_q <= '0;
        bit_q <= '0;
        ch_q  <= frame_i ? '0 : ch_next_o;
      end else if (tick) begin
        div_q <= '0;
        bit_q <= BIT_W'(bit_q + 1'b1);
      end else if (synced_q) begin
        div_q <= DIV_W'(div_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SUB_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              sub_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              en_i,
  output logic              ser_o,
  output logic              oe_o
);
  logic [BYTE_W-1:0] sh_q, load_val;

  // sub-rate bits are left-aligned so the MSB tap serves both formats
  assign load_val = sub_i ? {data_i[SUB_W-1:0], {(BYTE_W-SUB_W){1'b0}}} : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_o <= 1'b0;
    end else if (load_i) begin
      sh_q <= load_val;
      oe_o <= en_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign ser_o = sh_q[BYTE_W-1];
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned MAX_CH   = 128,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SUB_W    = 2,
  parameter int unsigned BASE_DIV = 8,
  localparam int unsigned CH_W    = $clog2(MAX_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              en_i,
  output logic [CH_W-1:0]   ch_req_o,
  output logic              ch_req_vld_o,
  output logic              ser_o,
  output logic              ser_oe_o
);
  logic load, shift, sub_next;

  tdm_tx_timing #(
    .MAX_CH(MAX_CH), .BYTE_W(BYTE_W), .SUB_W(SUB_W), .BASE_DIV(BASE_DIV)
  ) i_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .mode_i     (tx_mode_e'(mode_i)),
    .load_o     (load),
    .shift_o    (shift),
    .sub_next_o (sub_next),
    .ch_next_o  (ch_req_o),
    .req_vld_o  (ch_req_vld_o)
  );

  tdm_tx_shifter #(.BYTE_W(BYTE_W), .SUB_W(SUB_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .sub_i   (sub_next),
    .data_i  (data_i),
    .en_i    (en_i),
    .ser_o   (ser_o),
    .oe_o    (ser_oe_o)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk #(
  parameter int unsigned CH_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_i,
  input logic [CH_W-1:0] ch_req_o,
  input logic            ch_req_vld_o,
  input logic            ser_oe_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (frame_i) seen_q <= 1'b1;
  end

  p_idle_before_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!ser_oe_o && ch_req_o == '0 && !ch_req_vld_o));

  p_frame_starts_ch0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (ch_req_o == CH_W'(1)));

  p_req_moves_at_slot_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ch_req_o) && !$past(frame_i)) |-> $past(ch_req_vld_o));

  p_oe_moves_at_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ser_oe_o) |-> ($past(ch_req_vld_o) || $past(frame_i)));
endmodule

bind tdm_tx tdm_tx_chk #(.CH_W(CH_W)) i_tdm_tx_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_i      (frame_i),
  .ch_req_o     (ch_req_o),
  .ch_req_vld_o (ch_req_vld_o),
  .ser_oe_o     (ser_oe_o)
);

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] data;
  logic       en;
  logic [6:0] ch_req;
  logic       ch_req_vld;
  logic       ser;
  logic       ser_oe;
  logic [7:0] seed = 8'd0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tdm_tx i_tdm_tx (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .mode_i(mode),
    .data_i(data), .en_i(en), .ch_req_o(ch_req), .ch_req_vld_o(ch_req_vld),
    .ser_o(ser), .ser_oe_o(ser_oe)
  );

  function automatic logic [7:0] pat(int ch, logic [7:0] s);
    return 8'(ch * 37 + 11) ^ s;
  endfunction

  function automatic logic pen(int ch, logic [7:0] s);
    return ((ch + int'(s)) % 5) != 3;
  endfunction

  // parallel source model: answers the requested index
  always_comb begin
    data = pat(int'(ch_req), seed);
    en   = pen(int'(ch_req), seed);
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // {mode, seed}
  localparam logic [9:0] VEC [7] = '{
    {2'd0, 8'h00}, {2'd1, 8'h5a}, {2'd2, 8'hc3}, {2'd3, 8'h1e},
    {2'd2, 8'h77}, {2'd3, 8'h81}, {2'd0, 8'hf0}
  };

  // call at a negedge; returns at the negedge before the next frame edge
  task automatic run_frame(logic [1:0] m, logic [1:0] nxt, logic [7:0] s, bit pulse);
    int nch, nb, d;
    logic [7:0] b;
    seed = s;
    if (pulse) begin
      mode  = m;
      frame = 1'b1;
    end
    @(negedge clk);
    frame = 1'b0;
    case (m)
      2'd0: begin nch = 32;  nb = 8; d = 8; end
      2'd1: begin nch = 64;  nb = 8; d = 4; end
      2'd2: begin nch = 128; nb = 8; d = 2; end
      default: begin nch = 128; nb = 2; d = 8; end
    endcase
    for (int c = 0; c < nch; c++) begin
      b = pat(c, s);
      for (int j = 0; j < nb; j++) begin
        if (c == nch / 2 && j == 0) mode = nxt; // R8: mid-frame change must not act
        chk(ser_oe == pen(c, s), "R7 oe per slot", int'(ser_oe), int'(pen(c, s)));
        if (pen(c, s)) begin
          if (nb == 8)
            chk(ser == b[7-j], "R3 R2 R8 R9 msb-first byte bit", int'(ser), int'(b[7-j]));
          else
            chk(ser == b[1-j], "R4 R5 sub-rate bit", int'(ser), int'(b[1-j]));
        end
        if (j == nb - 1) begin
          chk(ch_req_vld == 1'b1, "R6 vld in last bit", int'(ch_req_vld), 1);
          chk(int'(ch_req) == (c + 1) % nch, "R6 next index", int'(ch_req), (c + 1) % nch);
        end else begin
          chk(ch_req_vld == 1'b0, "R6 vld low", int'(ch_req_vld), 0);
        end
        if (c == nch - 1 && j == nb - 1) repeat (d - 1) @(negedge clk);
        else repeat (d) @(negedge clk);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_oe == 1'b0, "R1 reset oe", int'(ser_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ser_oe == 1'b0, "R1 oe idle", int'(ser_oe), 0);
    chk(ch_req == 7'd0, "R1 req idle", int'(ch_req), 0);
    chk(ch_req_vld == 1'b0, "R1 vld idle", int'(ch_req_vld), 0);
    repeat (300) @(negedge clk);
    chk(ser_oe == 1'b0, "R1 oe unsynced", int'(ser_oe), 0);
    chk(ch_req_vld == 1'b0, "R1 vld unsynced", int'(ch_req_vld), 0);

    for (int i = 0; i < 7; i++) begin
      run_frame(VEC[i][9:8], (i < 6) ? VEC[i+1][9:8] : 2'd1, VEC[i][7:0], 1'b1);
    end
    // R9: no strobe, mode_i shows 1 but active mode 0 continues
    run_frame(2'd0, 2'd2, 8'h3c, 1'b0);
    // R8: strobe now takes mode_i
    run_frame(2'd2, 2'd2, 8'h95, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule